// File: doc/BRIEF.md
# Register Rename Map Table

This block turns architectural register numbers into physical tags for a scalar out-of-order core. Each cycle it can take one rename request: two source register numbers, a destination register number, a flag saying whether the destination is written, and a flag marking a branch. One clock later it returns the tags for both sources, the next free physical tag, the tag the destination held before, the free-list read position and the checkpoint slot that is current for that instruction.

Free tags come from a circular FIFO. Writing retires add displaced tags at its tail and writing renames take tags from its head. A branch stores a snapshot of the whole mapping in a small ring of checkpoint slots. A flush input picks one slot and a free-list position. The block then reloads the mapping from that slot and moves the free-list head back to that position. After reset the table fills itself one entry per cycle and shows a busy output for that whole time.

Top module: `rename_map_table`

## Requirements
- R1: `init_busy` is 1 from reset for NUM_TAGS cycles, then 0, and stays 0 until the next reset. `req_stall` is 1 while it is high.
- R2: After initialisation, register k maps to tag k for every k below NUM_ARCH.
- R3: Free-list slot k starts out holding tag NUM_ARCH+k, so writing renames get tags 34, 35, 36 and so on in order. `rsp_fl_head` gives the slot the shown tag was read from.
- R4: A request accepted (`req_vld`=1 and `req_stall`=0) at one rising edge raises `rsp_vld` and updates every `rsp_*` output at that same edge. A cycle with no accepted request leaves `rsp_vld` at 0.
- R5: A source register that was renamed earlier returns the most recent tag given to it.
- R6: `rsp_old_tag` is the tag the destination register held before this rename.
- R7: A request with `req_dst_wr`=0 still shows the next free tag on `rsp_dst_tag` but does not take it. The next writing rename gets the same tag.
- R8: An accepted branch stores the mapping, including its own destination write, in slot `rsp_ckpt` and moves the allocation slot forward by one modulo NUM_CKPT. Other requests report the current allocation slot.
- R9: While `flush` is 1, `req_stall` is 1. At that edge the mapping is reloaded from slot `flush_ckpt`, the free-list head becomes `flush_fl_head`, the allocation slot becomes `flush_ckpt`, and the number of live checkpoints becomes (`flush_ckpt` − oldest slot) mod NUM_CKPT.
- R10: A retire with `ret_vld`=1 and `ret_dst_wr`=1 adds `ret_old_tag` at the free-list tail.
- R11: When NUM_CKPT checkpoints are live, a branch request is stalled. A retire with `ret_ckpt_free`=1 releases the oldest checkpoint, and this lifts the stall from the next cycle on.
- R12: When the free list is empty, a request with `req_dst_wr`=1 is stalled. A request with `req_dst_wr`=0 is not stalled by this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_busy | output | 1 | Table is being initialised |
| req_vld | input | 1 | Rename request valid |
| req_src_a | input | IW | First source register |
| req_src_b | input | IW | Second source register |
| req_dst | input | IW | Destination register |
| req_dst_wr | input | 1 | Request writes its destination |
| req_branch | input | 1 | Request is a branch |
| req_stall | output | 1 | Request cannot be accepted this cycle |
| rsp_vld | output | 1 | Rename results valid |
| rsp_tag_a | output | TW | Tag of first source |
| rsp_tag_b | output | TW | Tag of second source |
| rsp_dst_tag | output | TW | Next free tag (allocated if writing) |
| rsp_old_tag | output | TW | Previous tag of destination |
| rsp_fl_head | output | TW | Free-list slot of shown tag |
| rsp_ckpt | output | CW | Checkpoint slot for this instruction |
| flush | input | 1 | Restore from checkpoint |
| flush_ckpt | input | CW | Slot to restore |
| flush_fl_head | input | TW | Free-list head to restore |
| ret_vld | input | 1 | Retire valid |
| ret_dst_wr | input | 1 | Retiring instruction wrote a register |
| ret_ckpt_free | input | 1 | Release oldest checkpoint |
| ret_old_tag | input | TW | Tag returned to free list |

## Verification
All rename results come out of one register stage. The bench drives a request just after a falling edge and reads the outputs at the next falling edge, which is half a cycle after the capturing rising edge. `req_stall` is combinational, so the bench reads it one time unit after driving, before any edge. Retire and flush take effect at the edge where they are presented. The bench sees their effect through the `rsp_*` outputs of the next rename, or through `req_stall` in the following cycle.

// File: rtl/rmt_pkg.sv
package rmt_pkg;

  // Next position on a ring of n slots
  function automatic int unsigned ring_next(int unsigned p, int unsigned n);
    return (p + 1 == n) ? 0 : p + 1;
  endfunction

  // Number of steps from b forward to a on a ring of n slots
  function automatic int unsigned ring_dist(int unsigned a, int unsigned b, int unsigned n);
    return (a + n - b) % n;
  endfunction

endpackage

// File: rtl/rmt_free_list.sv
module rmt_free_list #(
  parameter int TW       = 6,
  parameter int NUM_ARCH = 34
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_we,
  input  logic [TW-1:0] init_idx,
  input  logic          init_done,
  input  logic          pop,
  input  logic          push,
  input  logic [TW-1:0] push_tag,
  input  logic          restore,
  input  logic [TW-1:0] restore_head,
  output logic [TW-1:0] head_tag,
  output logic [TW-1:0] head_idx,
  output logic          empty
);
  localparam int DEPTH = 1 << TW;
  localparam int FREE  = DEPTH - NUM_ARCH;

  logic [TW-1:0] mem [DEPTH];
  logic [TW-1:0] head_q, tail_q;

  assign head_tag = mem[head_q];
  assign head_idx = head_q;
  assign empty    = (head_q == tail_q);

  always_ff @(posedge clk) begin
    if (init_we && int'(init_idx) < FREE)
      mem[init_idx] <= TW'(int'(init_idx) + NUM_ARCH);
    else if (push)
      mem[tail_q] <= push_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (restore)  head_q <= restore_head;
      else if (pop) head_q <= head_q + 1'b1;
      if (init_done) tail_q <= TW'(FREE);
      else if (push) tail_q <= tail_q + 1'b1;
    end
  end

  // R12: a tag is never taken from an empty list
  a_r12_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R10: a returned tag never overruns the head
  a_r10_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (tail_q + 1'b1) != head_q);
endmodule

// File: rtl/rmt_ckpt_ring.sv
module rmt_ckpt_ring
  import rmt_pkg::*;
#(
  parameter int NUM_CKPT = 4,
  parameter int NUM_ARCH = 34,
  parameter int TW       = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         save,
  input  logic [NUM_ARCH-1:0][TW-1:0]  save_map,
  input  logic                         release_i,
  input  logic                         restore,
  input  logic [$clog2(NUM_CKPT)-1:0]  restore_slot,
  output logic [NUM_ARCH-1:0][TW-1:0]  restore_map,
  output logic [$clog2(NUM_CKPT)-1:0]  alloc_slot,
  output logic                         full
);
  localparam int CW = $clog2(NUM_CKPT);
  localparam int NW = $clog2(NUM_CKPT + 1);

  logic [NUM_ARCH-1:0][TW-1:0] snap [NUM_CKPT];
  logic [CW-1:0] aptr_q, rptr_q;
  logic [NW-1:0] live_q;

  assign restore_map = snap[restore_slot];
  assign alloc_slot  = aptr_q;
  assign full        = (int'(live_q) == NUM_CKPT);

  always_ff @(posedge clk) begin
    if (save) snap[aptr_q] <= save_map;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aptr_q <= '0;
      rptr_q <= '0;
      live_q <= '0;
    end else if (restore) begin
      aptr_q <= restore_slot;
      live_q <= NW'(ring_dist(int'(restore_slot), int'(rptr_q), NUM_CKPT));
    end else begin
      if (save)      aptr_q <= CW'(ring_next(int'(aptr_q), NUM_CKPT));
      if (release_i) rptr_q <= CW'(ring_next(int'(rptr_q), NUM_CKPT));
      live_q <= live_q + NW'(save) - NW'(release_i);
    end
  end

  // R11: no snapshot is written into a full ring
  a_r11_no_save_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    save |-> !full);
  // R11: a release always has a live checkpoint behind it
  a_r11_release_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    (release_i && !restore) |-> live_q != '0);
endmodule

// File: rtl/rename_map_table.sv
module rename_map_table
  import rmt_pkg::*;
#(
  parameter int NUM_ARCH = 34,
  parameter int NUM_TAGS = 64,
  parameter int NUM_CKPT = 4,
  localparam int IW = $clog2(NUM_ARCH),
  localparam int TW = $clog2(NUM_TAGS),
  localparam int CW = $clog2(NUM_CKPT)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          init_busy,
  input  logic          req_vld,
  input  logic [IW-1:0] req_src_a,
  input  logic [IW-1:0] req_src_b,
  input  logic [IW-1:0] req_dst,
  input  logic          req_dst_wr,
  input  logic          req_branch,
  output logic          req_stall,
  output logic          rsp_vld,
  output logic [TW-1:0] rsp_tag_a,
  output logic [TW-1:0] rsp_tag_b,
  output logic [TW-1:0] rsp_dst_tag,
  output logic [TW-1:0] rsp_old_tag,
  output logic [TW-1:0] rsp_fl_head,
  output logic [CW-1:0] rsp_ckpt,
  input  logic          flush,
  input  logic [CW-1:0] flush_ckpt,
  input  logic [TW-1:0] flush_fl_head,
  input  logic          ret_vld,
  input  logic          ret_dst_wr,
  input  logic          ret_ckpt_free,
  input  logic [TW-1:0] ret_old_tag
);
  // Initialisation sequencer: one map entry and one free-list slot per cycle
  logic          busy_q;
  logic [TW-1:0] init_cnt_q;
  logic          init_last;
  assign init_last = busy_q && (init_cnt_q == TW'(NUM_TAGS - 1));
  assign init_busy = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b1;
      init_cnt_q <= '0;
    end else if (busy_q) begin
      init_cnt_q <= init_cnt_q + 1'b1;
      if (init_last) busy_q <= 1'b0;
    end
  end

  // Named events used by the submodules and the assertions
  logic          fl_empty, ck_full;
  logic [TW-1:0] fl_head_tag, fl_head_idx;
  logic [CW-1:0] ck_slot;
  logic [NUM_ARCH-1:0][TW-1:0] ck_map, map_q, map_next;
  logic          ren_go, ren_alloc, ren_ckpt, ret_push, ret_free;

  assign req_stall = busy_q | flush | (req_branch & ck_full) | (req_dst_wr & fl_empty);
  assign ren_go    = req_vld & ~req_stall;
  assign ren_alloc = ren_go & req_dst_wr;
  assign ren_ckpt  = ren_go & req_branch;
  assign ret_push  = ret_vld & ret_dst_wr;
  assign ret_free  = ret_vld & ret_ckpt_free;

  // Mapping update: init, restore, or one destination write
  always_comb begin
    map_next = map_q;
    if (busy_q) begin
      if (int'(init_cnt_q) < NUM_ARCH) map_next[IW'(init_cnt_q)] = init_cnt_q;
    end else if (flush) begin
      map_next = ck_map;
    end else if (ren_alloc) begin
      map_next[req_dst] = fl_head_tag;
    end
  end

  always_ff @(posedge clk) map_q <= map_next;

  rmt_free_list #(.TW(TW), .NUM_ARCH(NUM_ARCH)) i_free_list (
    .clk, .rst_n,
    .init_we     (busy_q),
    .init_idx    (init_cnt_q),
    .init_done   (init_last),
    .pop         (ren_alloc),
    .push        (ret_push),
    .push_tag    (ret_old_tag),
    .restore     (flush),
    .restore_head(flush_fl_head),
    .head_tag    (fl_head_tag),
    .head_idx    (fl_head_idx),
    .empty       (fl_empty)
  );

  rmt_ckpt_ring #(.NUM_CKPT(NUM_CKPT), .NUM_ARCH(NUM_ARCH), .TW(TW)) i_ckpt_ring (
    .clk, .rst_n,
    .save        (ren_ckpt),
    .save_map    (map_next),
    .release_i   (ret_free),
    .restore     (flush),
    .restore_slot(flush_ckpt),
    .restore_map (ck_map),
    .alloc_slot  (ck_slot),
    .full        (ck_full)
  );

  // Response stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld     <= 1'b0;
      rsp_tag_a   <= '0;
      rsp_tag_b   <= '0;
      rsp_dst_tag <= '0;
      rsp_old_tag <= '0;
      rsp_fl_head <= '0;
      rsp_ckpt    <= '0;
    end else begin
      rsp_vld <= ren_go;
      if (ren_go) begin
        rsp_tag_a   <= map_q[req_src_a];
        rsp_tag_b   <= map_q[req_src_b];
        rsp_dst_tag <= fl_head_tag;
        rsp_old_tag <= map_q[req_dst];
        rsp_fl_head <= fl_head_idx;
        rsp_ckpt    <= ck_slot;
      end
    end
  end

  // R1: busy never comes back without a reset
  a_r1_busy_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
    !init_busy |=> !init_busy);
  // R4: no result appears for a cycle in which the table was still busy
  a_r4_no_rsp_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |-> !$past(init_busy));
  // R9: a flush cycle produces no rename result
  a_r9_flush_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !rsp_vld);
  // R12: a writing rename never leaves with an empty free list
  a_r12_alloc_has_tag: assert property (@(posedge clk) disable iff (!rst_n)
    ren_alloc |-> !fl_empty);
endmodule

// File: tb/test_rename_map_table.sv
module test_rename_map_table;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 34, NT = 64, NC = 4;
  localparam int IW = $clog2(NA), TW = $clog2(NT), CW = $clog2(NC);

  logic clk = 1'b0, rst_n = 1'b0;
  logic init_busy, req_vld = 0, req_dst_wr = 0, req_branch = 0, req_stall;
  logic [IW-1:0] req_src_a = 0, req_src_b = 0, req_dst = 0;
  logic rsp_vld;
  logic [TW-1:0] rsp_tag_a, rsp_tag_b, rsp_dst_tag, rsp_old_tag, rsp_fl_head;
  logic [CW-1:0] rsp_ckpt;
  logic flush = 0, ret_vld = 0, ret_dst_wr = 0, ret_ckpt_free = 0;
  logic [CW-1:0] flush_ckpt = 0;
  logic [TW-1:0] flush_fl_head = 0, ret_old_tag = 0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rename_map_table #(.NUM_ARCH(NA), .NUM_TAGS(NT), .NUM_CKPT(NC)) i_rename_map_table (
    .clk, .rst_n, .init_busy, .req_vld, .req_src_a, .req_src_b, .req_dst,
    .req_dst_wr, .req_branch, .req_stall, .rsp_vld, .rsp_tag_a, .rsp_tag_b,
    .rsp_dst_tag, .rsp_old_tag, .rsp_fl_head, .rsp_ckpt, .flush, .flush_ckpt,
    .flush_fl_head, .ret_vld, .ret_dst_wr, .ret_ckpt_free, .ret_old_tag);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Free-list slot k holds tag NA+k at start (R3)
  function automatic int init_tag(int k);
    return NA + k;
  endfunction

  // Present one request for one cycle; outputs sampled at the next falling edge
  task automatic ren(int a, int b, int d, bit wr, bit br);
    req_vld = 1; req_src_a = IW'(a); req_src_b = IW'(b); req_dst = IW'(d);
    req_dst_wr = wr; req_branch = br;
    @(negedge clk);
    req_vld = 0; req_dst_wr = 0; req_branch = 0;
  endtask

  task automatic expect_rsp(string req, int ta, int tb, int td, int told, int hd, int ck);
    chk({req, " vld"}, int'(rsp_vld), 1);
    if (ta >= 0)   chk({req, " tag_a"}, int'(rsp_tag_a), ta);
    if (tb >= 0)   chk({req, " tag_b"}, int'(rsp_tag_b), tb);
    if (td >= 0)   chk({req, " dst"}, int'(rsp_dst_tag), td);
    if (told >= 0) chk({req, " old"}, int'(rsp_old_tag), told);
    if (hd >= 0)   chk({req, " head"}, int'(rsp_fl_head), hd);
    if (ck >= 0)   chk({req, " ckpt"}, int'(rsp_ckpt), ck);
  endtask

  task automatic retire(bit wr, bit cfree, int old);
    ret_vld = 1; ret_dst_wr = wr; ret_ckpt_free = cfree; ret_old_tag = TW'(old);
    @(negedge clk);
    ret_vld = 0; ret_dst_wr = 0; ret_ckpt_free = 0;
  endtask

  task automatic t_reset_init();
    int n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    chk("R1 busy after reset", int'(init_busy), 1);
    req_vld = 1; req_dst_wr = 1; #1;
    chk("R1 stall while busy", int'(req_stall), 1);
    req_vld = 0; req_dst_wr = 0;
    while (init_busy && n < 1000) begin @(negedge clk); n++; end
    chk("R1 init length", n, NT);
    chk("R4 no rsp without request", int'(rsp_vld), 0);
  endtask

  task automatic t_basic();
    ren(1, 2, 3, 1, 0);
    expect_rsp("R2 R3 first", 1, 2, init_tag(0), 3, 0, 0);
    ren(1, 3, 4, 1, 0);
    expect_rsp("R5 R3 second", 1, 34, init_tag(1), 4, 1, 0);
    @(negedge clk);
    chk("R4 idle no rsp", int'(rsp_vld), 0);
    ren(3, 4, 4, 0, 1);
    expect_rsp("R7 R8 branch", 34, 35, 36, 35, 2, 0);
    ren(1, 2, 3, 1, 0);
    expect_rsp("R6 R7 after branch", 1, 2, 36, 34, 2, 1);
    ren(1, 3, 4, 1, 0);
    expect_rsp("R5 R6 R8 next", 1, 36, 37, 35, 3, 1);
  endtask

  task automatic t_retire_flush();
    retire(1, 0, 3);
    retire(1, 0, 4);
    flush = 1; flush_ckpt = 0; flush_fl_head = 3; req_vld = 1; #1;
    chk("R9 stall during flush", int'(req_stall), 1);
    @(negedge clk);
    flush = 0; req_vld = 0;
    chk("R9 no rsp from flush cycle", int'(rsp_vld), 0);
    ren(3, 4, 4, 1, 0);
    expect_rsp("R9 restored", 34, 35, 37, 35, 3, 0);
  endtask

  task automatic t_ckpt_full();
    for (int i = 0; i < NC; i++) begin
      ren(0, 0, 0, 0, 1);
      expect_rsp("R8 R11 fill", -1, -1, 38, -1, 4, i);
    end
    req_vld = 1; req_branch = 1; #1;
    chk("R11 branch stall when full", int'(req_stall), 1);
    req_branch = 0; #1;
    chk("R11 non-branch not stalled", int'(req_stall), 0);
    req_vld = 0;
    @(negedge clk);
    chk("R4 stalled request gives no rsp", int'(rsp_vld), 0);
    retire(0, 1, 0);
    req_branch = 1; #1;
    chk("R11 stall lifted after release", int'(req_stall), 0);
    req_branch = 0;
    ren(0, 0, 0, 0, 1);
    expect_rsp("R11 wrapped slot", -1, -1, -1, -1, -1, 0);
    flush = 1; flush_ckpt = 1; flush_fl_head = 4;
    @(negedge clk);
    flush = 0;
    ren(3, 4, 5, 0, 0);
    expect_rsp("R9 restore slot 1", 34, 37, 38, 5, 4, 1);
  endtask

  task automatic t_exhaust();
    for (int k = 0; k < 28; k++) begin
      ren(5, 5, 5, 1, 0);
      chk("R3 R10 alloc order", int'(rsp_dst_tag), (k < 26) ? 38 + k : 3 + (k - 26));
    end
    req_vld = 1; req_dst_wr = 1; #1;
    chk("R12 write stall when empty", int'(req_stall), 1);
    req_dst_wr = 0; #1;
    chk("R12 non-writing not stalled", int'(req_stall), 0);
    req_vld = 0;
    retire(1, 0, 40);
    ren(5, 6, 5, 1, 0);
    expect_rsp("R10 R12 refill", 4, 6, 40, 4, 32, 1);
  endtask

  initial begin
    t_reset_init();
    t_basic();
    t_retire_flush();
    t_ckpt_full();
    t_exhaust();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule